// File: doc/BRIEF.md
# Extended Immediate Constant Assembler

This block sits beside an instruction decoder that handles fixed 40-bit instruction words. It watches the word stream and builds the immediate constant that goes with each instruction. The constant begins as a short field in the first word of the instruction, called the base word. Zero to three extension words can follow it, and each one adds 40 bits above the bits already collected. A constant can therefore be 10, 50, 90 or 130 bits long.

The length of the constant is set independently of the operation size. The operation size is a separate 2-bit code that comes with the base word. When the last word of an instruction has been taken in, the block shows two results and pulses `done_o` for one cycle. The first result is the full constant, sign-extended to 130 bits. The second is the constant reduced to the operation size and sign-extended to 64 bits. The block also reports how many words the instruction used.

Sometimes a new base word arrives while extension words are still expected. The partial constant is then dropped, an error pulse is raised, and assembly restarts from the new base word.

Top module: `imm_assembler`

## Requirements
- R1: A word is taken in on each rising edge where `in_valid` is high, and `in_ready` is always high. `in_first` high marks a base word. In a base word, bits [9:0] hold the short immediate and bits [11:10] hold the extension count n (0 to 3). Bits [39:12] of a base word have no effect on any output.
- R2: The k-th extension word after a base word (k = 1..3) supplies constant bits [10+40(k-1)+39 : 10+40(k-1)].
- R3: `full_o` equals the assembled constant sign-extended from its top bit, bit 10+40n-1, to 130 bits.
- R4: `in_opsz` is sampled with the base word, using the codes 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits. `value_o` holds the low W bits of the constant, sign-extended from bit W-1 to 64 bits.
- R5: `done_o` is high for exactly the one cycle that follows the edge on which the last word of an instruction is taken in. For n = 0, the last word is the base word itself. `full_o`, `value_o` and `words_o` keep their values until the next `done_o`.
- R6: `words_o` equals 1+n for the instruction just completed.
- R7: A base word taken in while extension words are still expected raises `err_o` for one cycle after that edge. The partial constant is discarded, and the new base word starts a fresh assembly whose result is correct.
- R8: An extension word (`in_first` low) taken in while no extension is expected is ignored. It produces no `done_o` and no `err_o`, and it leaves the held outputs and the next result unchanged.
- R9: While `rst` is high and after it is released, `done_o` and `err_o` are low and `full_o`, `value_o` and `words_o` are zero, with no assembly in progress.
- R10: Cycles with `in_valid` low between the words of one instruction do not change the result or the moment `done_o` rises relative to the last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take a word (always high) |
| in_first | input | 1 | Input word is a base word |
| in_word | input | 40 | Instruction word |
| in_opsz | input | 2 | Operation size code, sampled with the base word |
| done_o | output | 1 | One-cycle pulse: a new constant is on the outputs |
| err_o | output | 1 | One-cycle pulse: an assembly was cut short by a new base word |
| full_o | output | 130 | Constant sign-extended to 130 bits |
| value_o | output | 64 | Constant reduced to the operation size, sign-extended to 64 bits |
| words_o | output | 3 | Words used by the completed instruction |

## Verification
The completion pulse and the error pulse can rise in the same cycle. This happens when a base word with an extension count of zero interrupts an assembly that is still waiting for extension words. The bench provokes this by sending one extension word of a three-word instruction and then a short base word. It then requires both pulses together, with the outputs carrying only the new base word's value and a word count of one. A second case interrupts with a base word that does have extensions. In that case only the error pulse may appear, and the later completion must show no trace of the discarded bits.

// File: rtl/imm_pkg.sv
package imm_pkg;

    localparam int WORD_W  = 40;
    localparam int IMM_W   = 10;
    localparam int CNT_W   = 2;
    localparam int MAX_EXT = (1 << CNT_W) - 1;
    localparam int FULL_W  = IMM_W + MAX_EXT * WORD_W;
    localparam int VAL_W   = 64;
    localparam int NSIZE   = 4;
    localparam int SZ_W    = $clog2(NSIZE);
    localparam int WCNT_W  = $clog2(MAX_EXT + 2);
    localparam int CNT_LSB = IMM_W;

    typedef enum logic [SZ_W-1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } opsz_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXT  = 1'b1
    } seq_st_e;

    typedef struct packed {
        logic             take_base;
        logic             take_ext;
        logic             finish;
        logic             abort;
        logic [CNT_W-1:0] slot;
        logic [CNT_W-1:0] n_ext;
    } seq_ctl_t;

    function automatic logic [FULL_W-1:0] sext_full(
        input logic [FULL_W-1:0] raw,
        input logic [CNT_W-1:0]  n
    );
        logic [FULL_W-1:0] res;
        int top;
        top = IMM_W + WORD_W * int'(n) - 1;
        for (int i = 0; i < FULL_W; i++) begin
            res[i] = (i <= top) ? raw[i] : raw[top];
        end
        return res;
    endfunction

endpackage

// File: rtl/imm_seq.sv
module imm_seq
    import imm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             first,
    input  logic [CNT_W-1:0] base_cnt,
    output seq_ctl_t         ctl
);

    seq_st_e          st_q;
    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] total_q;

    always_comb begin
        ctl           = '0;
        ctl.take_base = take & first;
        ctl.take_ext  = take & ~first & (st_q == ST_EXT);
        ctl.abort     = ctl.take_base & (st_q == ST_EXT);
        ctl.slot      = total_q - remain_q;
        ctl.finish    = (ctl.take_base & (base_cnt == '0))
                      | (ctl.take_ext & (remain_q == CNT_W'(1)));
        ctl.n_ext     = ctl.take_base ? base_cnt : total_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            remain_q <= '0;
            total_q  <= '0;
        end else if (ctl.take_base) begin
            total_q  <= base_cnt;
            remain_q <= base_cnt;
            st_q     <= (base_cnt != '0) ? ST_EXT : ST_IDLE;
        end else if (ctl.take_ext) begin
            remain_q <= remain_q - CNT_W'(1);
            if (remain_q == CNT_W'(1)) begin
                st_q <= ST_IDLE;
            end
        end
    end

    AST_EXT_REMAIN_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_EXT) |-> (remain_q != '0)); // R5

    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_EXT) |-> (remain_q <= total_q)); // R2

endmodule

// File: rtl/imm_accum.sv
module imm_accum
    import imm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  seq_ctl_t          ctl,
    input  logic [WORD_W-1:0] word,
    input  logic [SZ_W-1:0]   opsz_in,
    output logic [FULL_W-1:0] raw_next,
    output logic [SZ_W-1:0]   opsz_eff
);

    logic [FULL_W-1:0] raw_q;
    logic [SZ_W-1:0]   opsz_q;
    logic [MAX_EXT-1:0] slot_we;

    for (genvar g = 0; g < MAX_EXT; g++) begin : g_slot
        assign slot_we[g] = ctl.take_ext & (ctl.slot == CNT_W'(g));
    end

    always_comb begin
        raw_next = raw_q;
        if (ctl.take_base) begin
            raw_next = '0;
            raw_next[IMM_W-1:0] = word[IMM_W-1:0];
        end else begin
            for (int k = 0; k < MAX_EXT; k++) begin
                if (slot_we[k]) begin
                    raw_next[IMM_W + k*WORD_W +: WORD_W] = word;
                end
            end
        end
    end

    assign opsz_eff = ctl.take_base ? opsz_in : opsz_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            opsz_q <= '0;
        end else begin
            raw_q  <= raw_next;
            opsz_q <= opsz_eff;
        end
    end

    AST_ONE_SLOT_WRITE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slot_we)); // R2

endmodule

// File: rtl/imm_sizer.sv
module imm_sizer
    import imm_pkg::*;
(
    input  logic [FULL_W-1:0] full_i,
    input  logic [SZ_W-1:0]   opsz,
    output logic [VAL_W-1:0]  value
);

    logic [VAL_W-1:0] cand [NSIZE];

    for (genvar g = 0; g < NSIZE; g++) begin : g_sz
        localparam int W = 8 << g;
        if (W >= VAL_W) begin : g_wide
            assign cand[g] = full_i[VAL_W-1:0];
        end else begin : g_narrow
            assign cand[g] = {{(VAL_W-W){full_i[W-1]}}, full_i[W-1:0]};
        end
    end

    assign value = cand[opsz];

endmodule

// File: rtl/imm_assembler.sv
module imm_assembler
    import imm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_first,
    input  logic [WORD_W-1:0] in_word,
    input  logic [SZ_W-1:0]   in_opsz,
    output logic              done_o,
    output logic              err_o,
    output logic [FULL_W-1:0] full_o,
    output logic [VAL_W-1:0]  value_o,
    output logic [WCNT_W-1:0] words_o
);

    seq_ctl_t          ctl;
    logic [FULL_W-1:0] raw_next;
    logic [FULL_W-1:0] full_next;
    logic [SZ_W-1:0]   opsz_eff;
    logic [VAL_W-1:0]  sized;

    assign in_ready = 1'b1;

    imm_seq i_seq (
        .clk      (clk),
        .rst      (rst),
        .take     (in_valid & in_ready),
        .first    (in_first),
        .base_cnt (in_word[CNT_LSB +: CNT_W]),
        .ctl      (ctl)
    );

    imm_accum i_accum (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .word     (in_word),
        .opsz_in  (in_opsz),
        .raw_next (raw_next),
        .opsz_eff (opsz_eff)
    );

    assign full_next = sext_full(raw_next, ctl.n_ext);

    imm_sizer i_sizer (
        .full_i (full_next),
        .opsz   (opsz_eff),
        .value  (sized)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o  <= 1'b0;
            err_o   <= 1'b0;
            full_o  <= '0;
            value_o <= '0;
            words_o <= '0;
        end else begin
            done_o <= ctl.finish;
            err_o  <= ctl.abort;
            if (ctl.finish) begin
                full_o  <= full_next;
                value_o <= sized;
                words_o <= WCNT_W'(ctl.n_ext) + WCNT_W'(1);
            end
        end
    end

    AST_LOW_BYTE_AGREES: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (value_o[7:0] == full_o[7:0])); // R4

    AST_TOP_SIGN_COPY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (full_o[FULL_W-1] == full_o[IMM_W + WORD_W*(int'(words_o)-1) - 1])); // R3

    AST_WORDS_RANGE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (words_o >= WCNT_W'(1) && words_o <= WCNT_W'(MAX_EXT+1))); // R6

    AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(in_valid)); // R5

    AST_ERR_FROM_BASE: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $past(in_valid && in_first)); // R7

    AST_HOLD_WITHOUT_DONE: assert property (@(posedge clk) disable iff (rst)
        !done_o |=> (done_o || $stable(value_o))); // R5

endmodule

// File: tb/test_imm_assembler.sv
module test_imm_assembler;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         in_first = 1'b0;
    logic [39:0]  in_word = '0;
    logic [1:0]   in_opsz = '0;
    logic         done_o;
    logic         err_o;
    logic [129:0] full_o;
    logic [63:0]  value_o;
    logic [2:0]   words_o;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    imm_assembler i_imm_assembler (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_first (in_first),
        .in_word  (in_word),
        .in_opsz  (in_opsz),
        .done_o   (done_o),
        .err_o    (err_o),
        .full_o   (full_o),
        .value_o  (value_o),
        .words_o  (words_o)
    );

    localparam logic [9:0]  V_IMM [NV] = '{10'h1FF, 10'h200, 10'h200, 10'h155, 10'h000,
                                           10'h000, 10'h3FF, 10'h001, 10'h000, 10'h2AA};
    localparam logic [1:0]  V_N   [NV] = '{2'd0, 2'd0, 2'd0, 2'd1, 2'd1,
                                           2'd1, 2'd1, 2'd2, 2'd3, 2'd3};
    localparam logic [39:0] V_E1  [NV] = '{40'h0, 40'h0, 40'h0, 40'h00_0000_0001, 40'h80_0000_0000,
                                           40'h80_0000_0000, 40'h0, 40'h0, 40'hFF_FFFF_FFFF, 40'h0};
    localparam logic [39:0] V_E2  [NV] = '{40'h0, 40'h0, 40'h0, 40'h0, 40'h0,
                                           40'h0, 40'h0, 40'h12_3456_789A, 40'h0, 40'h0};
    localparam logic [39:0] V_E3  [NV] = '{40'h0, 40'h0, 40'h0, 40'h0, 40'h0,
                                           40'h0, 40'h0, 40'h0, 40'h0, 40'h80_0000_0000};
    localparam logic [1:0]  V_SZ  [NV] = '{2'd3, 2'd3, 2'd0, 2'd3, 2'd3,
                                           2'd2, 2'd0, 2'd3, 2'd3, 2'd2};
    localparam logic [63:0] V_VAL [NV] = '{64'h0000_0000_0000_01FF, 64'hFFFF_FFFF_FFFF_FE00,
                                           64'h0, 64'h0000_0000_0000_0555,
                                           64'hFFFE_0000_0000_0000, 64'h0,
                                           64'hFFFF_FFFF_FFFF_FFFF, 64'hE268_0000_0000_0001,
                                           64'h0003_FFFF_FFFF_FC00, 64'h0000_0000_0000_02AA};

    function automatic logic [129:0] model_full(input logic [9:0] imm, input logic [1:0] n,
                                                input logic [39:0] e1, input logic [39:0] e2,
                                                input logic [39:0] e3);
        logic [129:0] raw;
        logic [129:0] res;
        int top;
        raw = {e3, e2, e1, imm};
        top = 10 + 40 * int'(n) - 1;
        for (int i = 0; i < 130; i++) res[i] = (i <= top) ? raw[i] : raw[top];
        return res;
    endfunction

    function automatic logic [39:0] mkbase(input logic [1:0] n, input logic [9:0] imm);
        return {28'h5A5_A5A5, n, imm};
    endfunction

    task automatic chk(input string req, input logic [129:0] act, input logic [129:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic first, input logic [39:0] w, input logic [1:0] sz);
        in_valid = 1'b1;
        in_first = first;
        in_word  = w;
        in_opsz  = sz;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_word  = 40'hDE_ADBE_EF00;
        in_opsz  = 2'd1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9 done in reset", 130'(done_o), 130'(0));
        rst = 1'b0;
        @(negedge clk);
        chk("R9 done after reset", 130'(done_o), 130'(0));
        chk("R9 err after reset", 130'(err_o), 130'(0));
        chk("R9 full after reset", full_o, 130'(0));
        chk("R9 value after reset", 130'(value_o), 130'(0));
        chk("R9 words after reset", 130'(words_o), 130'(0));
        chk("R1 ready", 130'(in_ready), 130'(1));

        // R1 R2 R3 R4 R5 R6: vector table
        for (int v = 0; v < NV; v++) begin
            send(1'b1, mkbase(V_N[v], V_IMM[v]), V_SZ[v]);
            if (V_N[v] >= 2'd1) begin
                chk("R5 no done mid", 130'(done_o), 130'(0));
                send(1'b0, V_E1[v], 2'd0);
            end
            if (V_N[v] >= 2'd2) send(1'b0, V_E2[v], 2'd0);
            if (V_N[v] >= 2'd3) send(1'b0, V_E3[v], 2'd0);
            chk("R5 done pulse", 130'(done_o), 130'(1));
            chk("R4 value", 130'(value_o), 130'(V_VAL[v]));
            chk("R3 R2 full", full_o, model_full(V_IMM[v], V_N[v], V_E1[v], V_E2[v], V_E3[v]));
            chk("R6 words", 130'(words_o), 130'(V_N[v]) + 130'(1));
            chk("R7 no err", 130'(err_o), 130'(0));
        end
        chk("R3 top bit of 130-bit constant", 130'(full_o[129]), 130'(1));

        // R5: outputs hold, done falls
        idle(1);
        chk("R5 done falls", 130'(done_o), 130'(0));
        chk("R5 value held", 130'(value_o), 130'(64'h2AA));

        // R7: interrupt with a zero-extension base: err and done together
        send(1'b1, mkbase(2'd2, 10'h001), 2'd3);
        send(1'b0, 40'hFF_FFFF_FFFF, 2'd0);
        send(1'b1, mkbase(2'd0, 10'h005), 2'd3);
        chk("R7 err pulse", 130'(err_o), 130'(1));
        chk("R7 done same cycle", 130'(done_o), 130'(1));
        chk("R7 fresh value", 130'(value_o), 130'(5));
        chk("R7 fresh words", 130'(words_o), 130'(1));
        idle(1);
        chk("R7 err one cycle", 130'(err_o), 130'(0));

        // R7: interrupt with an extended base
        send(1'b1, mkbase(2'd1, 10'h100), 2'd3);
        send(1'b1, mkbase(2'd1, 10'h003), 2'd3);
        chk("R7 err on extended restart", 130'(err_o), 130'(1));
        chk("R7 no done on extended restart", 130'(done_o), 130'(0));
        send(1'b0, 40'h00_0000_0002, 2'd0);
        chk("R7 restart value", 130'(value_o), 130'(64'h803));
        chk("R7 restart err low", 130'(err_o), 130'(0));

        // R8: stray extension word while idle
        send(1'b0, 40'hFF_FFFF_FFFF, 2'd3);
        chk("R8 no done", 130'(done_o), 130'(0));
        chk("R8 no err", 130'(err_o), 130'(0));
        chk("R8 value held", 130'(value_o), 130'(64'h803));
        send(1'b1, mkbase(2'd0, 10'h007), 2'd3);
        chk("R8 next result", 130'(value_o), 130'(7));

        // R10: gaps between words
        send(1'b1, mkbase(2'd2, 10'h004), 2'd3);
        idle(2);
        send(1'b0, 40'h00_0000_0001, 2'd0);
        idle(1);
        chk("R10 no early done", 130'(done_o), 130'(0));
        send(1'b0, 40'h00_0000_0000, 2'd0);
        chk("R10 done after gaps", 130'(done_o), 130'(1));
        chk("R10 value", 130'(value_o), 130'(64'h404));
        chk("R10 words", 130'(words_o), 130'(3));

        // R4: opsz sampled with the base word only (16-bit)
        send(1'b1, mkbase(2'd1, 10'h000), 2'd1);
        send(1'b0, 40'h00_0000_0020, 2'd3);
        chk("R4 16-bit size from base", 130'(value_o), 130'(64'hFFFF_FFFF_FFFF_8000));

        finish_run();
    end

endmodule